// File: doc/BRIEF.md
# H-Bridge Direction and Decay Gate Sequencer

This block sits between a motor controller's digital command pins and the gate drivers of a four-switch H-bridge. It takes a direction input, an enable input, two decay-mode inputs, an active-low sleep input, a zero-current flag and a force-off line from the protection logic. From these it produces four switch-on controls: high-side and low-side for leg A (the positive motor terminal) and for leg B (the negative terminal). Each leg is sourcing (high switch on), sinking (low switch on) or floating (both off).

While enabled, the bridge drives the motor forward or in reverse. While disabled, the decay inputs select one of two behaviours. The first is a brake that shorts the winding through either the two high switches or the two low switches. The second is fast decay, which reverses the polarity of the bridge to pull the winding current down. In fast decay the zero-current flag floats the bridge so the current never changes sign.

Two timing guards wrap the decode. A wake-up timer keeps every switch off for a set number of clock cycles after the block leaves sleep or reset. A per-leg crossover guard keeps both switches of a leg off for a set number of cycles before either of them turns on again. Sleep and force-off clear the gates in the same cycle, ahead of every register.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With the block awake and past its wake-up interval, `force_off_i` low and `en_i` high, `dir_i`=1 settles to leg A sourcing and leg B sinking. `dir_i`=0 settles to leg A sinking and leg B sourcing. In this case `slow_decay_i`, `recirc_hi_i` and `zero_cur_i` have no effect. Sourcing means hi_on=1 and lo_on=0; sinking means hi_on=0 and lo_on=1.
- R2: With `en_i` low and `slow_decay_i` high, both legs settle to the same state. `recirc_hi_i`=1 makes both legs source, and `recirc_hi_i`=0 makes both legs sink. `dir_i` and `zero_cur_i` have no effect.
- R3: With `en_i` low, `slow_decay_i` low and `zero_cur_i` low, the bridge settles to the polarity opposite to `dir_i`. `dir_i`=1 gives leg A sinking and leg B sourcing, and `dir_i`=0 gives leg A sourcing and leg B sinking. `recirc_hi_i` has no effect.
- R4: With `en_i` low and `slow_decay_i` low, a high `zero_cur_i` turns all four switches off at the next rising edge, and they stay off while the flag stays high. This also holds when the wake-up interval ends during that time.
- R5: While `awake_i` is low, all four switch controls are 0 in the same cycle, whatever the other inputs are.
- R6: After reset is released, or after `awake_i` rises, all switches stay off through the first WAKE_CYCLES rising edges that sample `awake_i` high. The commanded state appears after edge WAKE_CYCLES+1.
- R7: While `force_off_i` is high, all four switch controls are 0 in the same cycle. Force-off takes precedence over every other input.
- R8: The high-side and low-side switch of one leg are never on together.
- R9: Once a leg's switches have turned off, neither switch turns on again until the leg has been off for DEAD_CYCLES clock cycles. Reversing a leg therefore shows both switches off after edges 1 to DEAD_CYCLES and the new switch on after edge DEAD_CYCLES+1. A leg that does not change is not disturbed.
- R10: A leg that has been off for at least DEAD_CYCLES cycles, or a leg that is turning off, takes its new state at the first rising edge after the input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction select |
| en_i | input | 1 | Bridge enable; low selects decay |
| slow_decay_i | input | 1 | 1 selects brake, 0 selects fast decay while disabled |
| recirc_hi_i | input | 1 | Brake path: 1 through high switches, 0 through low switches |
| awake_i | input | 1 | Active-low sleep: 0 puts the bridge to sleep |
| zero_cur_i | input | 1 | Winding current near zero |
| force_off_i | input | 1 | Protection override, all switches off |
| a_hi_on_o | output | 1 | Leg A high-side switch on |
| a_lo_on_o | output | 1 | Leg A low-side switch on |
| b_hi_on_o | output | 1 | Leg B high-side switch on |
| b_lo_on_o | output | 1 | Leg B low-side switch on |

## Verification
Two overlaps are provoked on purpose. In the first, force-off is raised in the very cycle in which a reversing leg's crossover time expires. The bench requires every switch to stay off across that edge, and the new switch to come on at the first edge after release, without a second crossover wait. In the second, the zero-current flag is held high in fast decay while the wake-up interval runs out. The bridge must stay floating past the end of the interval, and the fast-decay polarity must appear one edge after the flag drops. Around these cases, a sweep of all 32 combinations of the five decode inputs is judged against a model of the mode table written in the bench.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'b00,
    LEG_SRC = 2'b01,
    LEG_SNK = 2'b10
  } leg_t;
endpackage

// File: rtl/hbg_wake_timer.sv
module hbg_wake_timer #(
  parameter int WAKE_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake_i,
  output logic ready_o
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!awake_i)   cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + CW'(1);
  end

  assign ready_o = (cnt == LAST);
endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  logic permit_i,
  input  logic dir_i,
  input  logic en_i,
  input  logic slow_decay_i,
  input  logic recirc_hi_i,
  input  logic zero_cur_i,
  output leg_t tgt_a_o,
  output leg_t tgt_b_o
);
  always_comb begin
    tgt_a_o = LEG_OFF;
    tgt_b_o = LEG_OFF;
    if (permit_i) begin
      if (en_i) begin
        // drive: polarity follows direction
        tgt_a_o = dir_i ? LEG_SRC : LEG_SNK;
        tgt_b_o = dir_i ? LEG_SNK : LEG_SRC;
      end else if (slow_decay_i) begin
        // brake: both legs on one rail
        tgt_a_o = recirc_hi_i ? LEG_SRC : LEG_SNK;
        tgt_b_o = recirc_hi_i ? LEG_SRC : LEG_SNK;
      end else if (!zero_cur_i) begin
        // fast decay: opposite polarity until the current reaches zero
        tgt_a_o = dir_i ? LEG_SNK : LEG_SRC;
        tgt_b_o = dir_i ? LEG_SRC : LEG_SNK;
      end
    end
  end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  leg_t tgt_i,
  output logic hi_on_o,
  output logic lo_on_o
);
  localparam int DW = $clog2(DEAD_CYCLES + 1);
  localparam logic [DW-1:0] GAP_DONE = DW'(DEAD_CYCLES);

  leg_t          cur;
  logic [DW-1:0] gap;   // cycles this leg has spent with both switches off

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= LEG_OFF;
      gap <= GAP_DONE;
    end else if (tgt_i == cur) begin
      if (cur == LEG_OFF && gap != GAP_DONE) gap <= gap + DW'(1);
    end else if (cur != LEG_OFF) begin
      cur <= LEG_OFF;             // turning off is never delayed
      gap <= DW'(1);
    end else if (gap == GAP_DONE) begin
      cur <= tgt_i;               // crossover time served
    end else begin
      gap <= gap + DW'(1);
    end
  end

  assign hi_on_o = (cur == LEG_SRC);
  assign lo_on_o = (cur == LEG_SNK);
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int WAKE_CYCLES = 50000,
  parameter int DEAD_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic en_i,
  input  logic slow_decay_i,
  input  logic recirc_hi_i,
  input  logic awake_i,
  input  logic zero_cur_i,
  input  logic force_off_i,
  output logic a_hi_on_o,
  output logic a_lo_on_o,
  output logic b_hi_on_o,
  output logic b_lo_on_o
);
  localparam int NLEG = 2;

  logic       ready;
  logic       kill;
  logic       permit;
  leg_t       tgt [NLEG];
  logic [NLEG-1:0] hi_on;
  logic [NLEG-1:0] lo_on;

  hbg_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .awake_i (awake_i),
    .ready_o (ready)
  );

  assign kill   = force_off_i | ~awake_i;
  assign permit = ready & ~kill;

  hbg_decode u_dec (
    .permit_i     (permit),
    .dir_i        (dir_i),
    .en_i         (en_i),
    .slow_decay_i (slow_decay_i),
    .recirc_hi_i  (recirc_hi_i),
    .zero_cur_i   (zero_cur_i),
    .tgt_a_o      (tgt[0]),
    .tgt_b_o      (tgt[1])
  );

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hbg_leg #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt_i   (tgt[g]),
      .hi_on_o (hi_on[g]),
      .lo_on_o (lo_on[g])
    );
  end

  // sleep and force-off clear the gates without waiting for a clock edge
  assign a_hi_on_o = hi_on[0] & ~kill;
  assign a_lo_on_o = lo_on[0] & ~kill;
  assign b_hi_on_o = hi_on[1] & ~kill;
  assign b_lo_on_o = lo_on[1] & ~kill;
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk #(
  parameter int WAKE_CYCLES = 50000,
  parameter int DEAD_CYCLES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic slow_decay_i,
  input logic awake_i,
  input logic zero_cur_i,
  input logic force_off_i,
  input logic a_hi_on_o,
  input logic a_lo_on_o,
  input logic b_hi_on_o,
  input logic b_lo_on_o
);
  localparam int DW  = $clog2(DEAD_CYCLES + 1);
  localparam int WCW = $clog2(WAKE_CYCLES + 2);
  localparam logic [DW-1:0]  GAP_MAX  = DW'(DEAD_CYCLES);
  localparam logic [WCW-1:0] WAKE_END = WCW'(WAKE_CYCLES);
  localparam logic [WCW-1:0] WAKE_SAT = WCW'(WAKE_CYCLES + 1);

  logic [DW-1:0]  gap_a, gap_b;
  logic [WCW-1:0] wcnt;
  logic           any_on;

  assign any_on = a_hi_on_o | a_lo_on_o | b_hi_on_o | b_lo_on_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_a <= GAP_MAX;
      gap_b <= GAP_MAX;
      wcnt  <= '0;
    end else begin
      if (a_hi_on_o | a_lo_on_o) gap_a <= '0;
      else if (gap_a != GAP_MAX) gap_a <= gap_a + DW'(1);
      if (b_hi_on_o | b_lo_on_o) gap_b <= '0;
      else if (gap_b != GAP_MAX) gap_b <= gap_b + DW'(1);
      if (!awake_i)              wcnt <= '0;
      else if (wcnt != WAKE_SAT) wcnt <= wcnt + WCW'(1);
    end
  end

  a_r8_leg_a_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi_on_o && a_lo_on_o));
  a_r8_leg_b_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_hi_on_o && b_lo_on_o));
  a_r9_gap_leg_a: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_hi_on_o) || $rose(a_lo_on_o)) |-> (gap_a >= GAP_MAX));
  a_r9_gap_leg_b: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(b_hi_on_o) || $rose(b_lo_on_o)) |-> (gap_b >= GAP_MAX));
  a_r5_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    !awake_i |-> !any_on);
  a_r7_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |-> !any_on);
  a_r6_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt <= WAKE_END) |-> !any_on);
  a_r4_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !slow_decay_i && zero_cur_i) |=> !any_on);
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
  .WAKE_CYCLES (WAKE_CYCLES),
  .DEAD_CYCLES (DEAD_CYCLES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en_i         (en_i),
  .slow_decay_i (slow_decay_i),
  .awake_i      (awake_i),
  .zero_cur_i   (zero_cur_i),
  .force_off_i  (force_off_i),
  .a_hi_on_o    (a_hi_on_o),
  .a_lo_on_o    (a_lo_on_o),
  .b_hi_on_o    (b_hi_on_o),
  .b_lo_on_o    (b_lo_on_o)
);

// File: tb/hb_gate_ctrl_tb.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb;
  localparam int WAKE = 20;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir = 1'b1, en = 1'b1, slow = 1'b0, rhi = 1'b0;
  logic awake = 1'b1, zc = 1'b0, frc = 1'b0;
  logic a_hi, a_lo, b_hi, b_lo;
  logic [3:0] g;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign g = {a_hi, a_lo, b_hi, b_lo};

  hb_gate_ctrl #(.WAKE_CYCLES(WAKE), .DEAD_CYCLES(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_i(dir), .en_i(en), .slow_decay_i(slow),
    .recirc_hi_i(rhi), .awake_i(awake), .zero_cur_i(zc), .force_off_i(frc),
    .a_hi_on_o(a_hi), .a_lo_on_o(a_lo), .b_hi_on_o(b_hi), .b_lo_on_o(b_lo)
  );

  // per leg: source = 2'b10 (hi,lo), sink = 2'b01, off = 2'b00
  function automatic logic [3:0] model(input logic d, e, s, h, z);
    if (e)      return d ? 4'b1001 : 4'b0110;
    else if (s) return h ? 4'b1010 : 4'b0101;
    else if (z) return 4'b0000;
    else        return d ? 4'b0110 : 4'b1001;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    n_run++;
    if (g !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, g, exp);
    end
  endtask

  task automatic settle();
    repeat (DEAD + 3) tick();
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R6: reset state and the wake-up interval after reset
    repeat (3) tick();
    chk("R6 reset state", 4'b0000);
    rst_n = 1'b1;
    repeat (WAKE) tick();
    chk("R6 off through wake interval after reset", 4'b0000);
    tick();
    chk("R6 forward after wake interval", 4'b1001);

    // R1 R2 R3 R4: sweep of all decode input combinations
    for (int i = 0; i < 32; i++) begin
      string t;
      {zc, rhi, slow, en, dir} = i[4:0];
      settle();
      if (en)        t = "R1 sweep drive";
      else if (slow) t = "R2 sweep brake";
      else if (zc)   t = "R4 sweep zero-current release";
      else           t = "R3 sweep fast decay";
      chk(t, model(dir, en, slow, rhi, zc));
    end

    // R10: turn-on from a long off period takes one edge
    en = 1'b0; slow = 1'b0; zc = 1'b1; dir = 1'b1;
    settle();
    chk("R4 fast decay floated", 4'b0000);
    en = 1'b1; zc = 1'b0;
    tick();
    chk("R10 one-edge turn-on", 4'b1001);

    // R9: reversal holds both legs off for DEAD cycles
    dir = 1'b0;
    tick();
    chk("R9 reversal edge 1 off", 4'b0000);
    repeat (DEAD - 1) tick();
    chk("R9 reversal last dead cycle off", 4'b0000);
    tick();
    chk("R9 reversal new switch on", 4'b0110);

    // R9: brake on high side from forward; leg A undisturbed
    dir = 1'b1;
    settle();
    en = 1'b0; slow = 1'b1; rhi = 1'b1;
    tick();
    chk("R9 leg A kept, leg B off", 4'b1000);
    repeat (DEAD) tick();
    chk("R2 high-side brake", 4'b1010);

    // R5: sleep clears gates at once and ignores inputs
    en = 1'b1; slow = 1'b0; rhi = 1'b0; dir = 1'b1;
    settle();
    awake = 1'b0;
    #1;
    chk("R5 sleep same cycle", 4'b0000);
    en = 1'b0; slow = 1'b1; rhi = 1'b1;
    repeat (3) tick();
    chk("R5 sleep ignores brake command", 4'b0000);
    en = 1'b1; slow = 1'b0; rhi = 1'b0;
    awake = 1'b1;
    repeat (WAKE) tick();
    chk("R6 off through wake interval after sleep", 4'b0000);
    tick();
    chk("R6 forward after wake from sleep", 4'b1001);

    // R7: force-off overrides at once
    frc = 1'b1;
    #1;
    chk("R7 force-off same cycle", 4'b0000);
    repeat (2) tick();
    chk("R7 force-off held", 4'b0000);
    frc = 1'b0;
    repeat (DEAD + 1) tick();
    chk("R7 recovery after release", 4'b1001);

    // overlap: force-off at the edge where crossover time expires
    dir = 1'b0;
    repeat (DEAD) tick();
    chk("R9 off before expiry", 4'b0000);
    frc = 1'b1;
    tick();
    chk("R7 force-off at dead-time expiry", 4'b0000);
    frc = 1'b0;
    tick();
    chk("R9 on one edge after release", 4'b0110);

    // overlap: zero-current held while the wake interval ends
    awake = 1'b0;
    tick();
    en = 1'b0; slow = 1'b0; dir = 1'b1; zc = 1'b1;
    awake = 1'b1;
    repeat (WAKE + 3) tick();
    chk("R4 zero-current over wake end", 4'b0000);
    zc = 1'b0;
    tick();
    chk("R3 fast decay after flag drops", 4'b0110);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule